// File: doc/BRIEF.md
# Prioritized Status LED Controller

This block drives four discrete indicator LEDs and one two-element (green plus red) PHY indicator from board status signals. Three conditions compete for the same LEDs, and a fixed order decides between them. A power fault has first claim and makes every element blink. Module programming access comes next: the discrete LEDs stay lit and the PHY indicator switches between green and orange. In normal operation the LEDs show live status: stretched UART activity, two user pins, and the boot source.

Every input is asynchronous and passes through a two-stage synchronizer. A free-running divider produces the slow blink, and each UART line has a retriggerable pulse stretcher so that a short frame still gives a visible flash. All outputs are registered. A 1 on an output lights that element. The PHY indicator shows orange when the green and red elements are both lit.

Top module: `led_status_ctrl`

## Requirements
- R1: While power-good is 0, all four discrete LEDs and both PHY elements carry the same blink signal, and that signal changes state exactly every 2^(DIV_W-1) cycles.
- R2: While power-good is 1 and programming select is 1, the four discrete LEDs and the PHY green element are steadily 1, and the PHY red element toggles every 2^(DIV_W-1) cycles.
- R3: In normal operation (power-good 1, programming select 0), led_o[2] follows user_a_i and led_o[3] follows user_b_i.
- R4: In normal operation, led_o[0] (receive line) and led_o[1] (transmit line) light 4 cycles after their UART line first reads 0. Each stays lit while the line reads 0 and for HOLD_CYC+2 cycles after the line returns to 1, then goes dark on the next cycle.
- R5: In normal operation, phy_grn_o is 1, and phy_red_o is 1 when boot_sel_i is 0 (SD, orange) and 0 when boot_sel_i is 1 (QSPI, green).
- R6: A fault overrides programming mode and normal operation, and programming mode overrides normal operation. The inputs of the lower levels then have no effect on any output.
- R7: During and right after reset, all six outputs are 0. The blink divider restarts from zero.
- R8: A change on a static input (user pin, boot select, mode select) reaches the outputs on the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Power-good status, 1 = supplies good |
| prog_sel_i | input | 1 | 1 = module programming access selected |
| uart_rx_i | input | 1 | Bridge UART receive line, idle 1 |
| uart_tx_i | input | 1 | Bridge UART transmit line, idle 1 |
| user_a_i | input | 1 | User-defined pin shown on led_o[2] |
| user_b_i | input | 1 | User-defined pin shown on led_o[3] |
| boot_sel_i | input | 1 | Boot source, 1 = QSPI, 0 = SD |
| led_o | output | 4 | Discrete LEDs, 1 = lit |
| phy_grn_o | output | 1 | PHY green element, 1 = lit |
| phy_red_o | output | 1 | PHY red element, 1 = lit (with green gives orange) |

## Verification
The hardest behaviour to reach is the exact end of a stretched UART pulse. It depends on the two synchronizer stages, the counter reload and the output register together. The bench holds a line low, releases it on a falling clock edge, and then checks the LED is still lit HOLD_CYC+2 edges later and dark one edge after that. Blink rates are checked by counting transitions over exactly 32 clock intervals with a small divider width. Override is checked by activating every lower-level input while a higher condition holds.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [1:0] {
    LVL_FAULT = 2'd0,
    LVL_PROG  = 2'd1,
    LVL_RUN   = 2'd2
  } lvl_t;
endpackage

// File: rtl/led_sync.sv
module led_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      stg1 <= d_i;
      q_o  <= stg1;
    end
  end
endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int DIV_W = 26
) (
  input  logic clk,
  input  logic rst,
  output logic blink_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign blink_o = cnt[DIV_W-1];

  AST_BLINK_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(blink_o) |=> $stable(blink_o)); // R1
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int HOLD_CYC = 2500000,
  localparam int CW      = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic act_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!line_i) cnt <= CW'(HOLD_CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign act_o = (cnt != '0);

  AST_STRETCH_LIT: assert property (@(posedge clk) disable iff (rst)
    !line_i |=> act_o); // R4
endmodule

// File: rtl/led_prio_arb.sv
module led_prio_arb
  import led_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_i,
  input  logic       prog_i,
  input  logic       boot_i,
  input  logic [1:0] act_i,
  input  logic [1:0] user_i,
  input  logic       blink_i,
  output logic [3:0] led_o,
  output logic       grn_o,
  output logic       red_o
);
  lvl_t       lvl;
  logic [3:0] led_n;
  logic       grn_n, red_n;

  always_comb begin
    if (!pg_i)       lvl = LVL_FAULT;
    else if (prog_i) lvl = LVL_PROG;
    else             lvl = LVL_RUN;
  end

  always_comb begin
    unique case (lvl)
      LVL_FAULT: begin
        led_n = {4{blink_i}};
        grn_n = blink_i;
        red_n = blink_i;
      end
      LVL_PROG: begin
        led_n = 4'hF;
        grn_n = 1'b1;
        red_n = blink_i;
      end
      default: begin
        led_n = {user_i[1], user_i[0], act_i[1], act_i[0]};
        grn_n = 1'b1;
        red_n = !boot_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_o <= '0;
      grn_o <= 1'b0;
      red_o <= 1'b0;
    end else begin
      led_o <= led_n;
      grn_o <= grn_n;
      red_o <= red_n;
    end
  end

  AST_FAULT_UNISON: assert property (@(posedge clk) disable iff (rst)
    !pg_i |=> (led_o == {4{red_o}}) && (grn_o == red_o)); // R6
  AST_PROG_STEADY: assert property (@(posedge clk) disable iff (rst)
    (pg_i && prog_i) |=> (led_o == 4'hF) && grn_o); // R2
  AST_RUN_BOOT: assert property (@(posedge clk) disable iff (rst)
    (pg_i && !prog_i) |=> grn_o && (red_o == !$past(boot_i))); // R5
  AST_RUN_USER: assert property (@(posedge clk) disable iff (rst)
    (pg_i && !prog_i) |=> (led_o[3:2] == $past(user_i))); // R3
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl #(
  parameter int DIV_W    = 26,
  parameter int HOLD_CYC = 2500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_i,
  input  logic       prog_sel_i,
  input  logic       uart_rx_i,
  input  logic       uart_tx_i,
  input  logic       user_a_i,
  input  logic       user_b_i,
  input  logic       boot_sel_i,
  output logic [3:0] led_o,
  output logic       phy_grn_o,
  output logic       phy_red_o
);
  localparam int NUM_UART = 2;
  localparam int NUM_STAT = 5;

  logic [NUM_UART-1:0] uart_s, act;
  logic [NUM_STAT-1:0] stat_s;
  logic                blink;

  led_sync #(.W(NUM_UART), .RST_VAL({NUM_UART{1'b1}})) u_sync_uart (
    .clk(clk), .rst(rst), .d_i({uart_tx_i, uart_rx_i}), .q_o(uart_s));

  led_sync #(.W(NUM_STAT), .RST_VAL({NUM_STAT{1'b0}})) u_sync_stat (
    .clk(clk), .rst(rst),
    .d_i({boot_sel_i, user_b_i, user_a_i, prog_sel_i, pwr_good_i}),
    .q_o(stat_s));

  led_blink_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .blink_o(blink));

  for (genvar i = 0; i < NUM_UART; i++) begin : g_str
    led_stretch #(.HOLD_CYC(HOLD_CYC)) u_str (
      .clk(clk), .rst(rst), .line_i(uart_s[i]), .act_o(act[i]));
  end

  led_prio_arb u_arb (
    .clk(clk), .rst(rst),
    .pg_i(stat_s[0]), .prog_i(stat_s[1]), .boot_i(stat_s[4]),
    .act_i(act), .user_i(stat_s[3:2]), .blink_i(blink),
    .led_o(led_o), .grn_o(phy_grn_o), .red_o(phy_red_o));

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (led_o == 4'h0) && !phy_grn_o && !phy_red_o); // R7
endmodule

// File: tb/sim_led_status_ctrl.sv
module sim_led_status_ctrl;
  localparam int CLK_PER = 10;
  localparam int DIV_W   = 4;
  localparam int HOLD    = 12;
  localparam int HALF    = 1 << (DIV_W - 1);

  logic clk = 1'b0, rst = 1'b1;
  logic pg = 1'b0, prog = 1'b0, rx = 1'b1, tx = 1'b1, ua = 1'b0, ub = 1'b0, boot = 1'b1;
  logic [3:0] led;
  logic grn, red;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  led_status_ctrl #(.DIV_W(DIV_W), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .pwr_good_i(pg), .prog_sel_i(prog),
    .uart_rx_i(rx), .uart_tx_i(tx), .user_a_i(ua), .user_b_i(ub),
    .boot_sel_i(boot), .led_o(led), .phy_grn_o(grn), .phy_red_o(red));

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Counts transitions of a selected output over 32 intervals; checks steady bits.
  task automatic count_toggles(input string req, input int sel, input logic [4:0] steady_exp,
                               input bit chk_steady, output int tog);
    logic prev, cur;
    tog = 0;
    edges(1);
    prev = (sel == 0) ? red : led[0];
    for (int i = 0; i < 32; i++) begin
      edges(1);
      cur = (sel == 0) ? red : led[0];
      if (cur != prev) tog++;
      prev = cur;
      if (chk_steady) check(req, {1'b0, led, grn}, {1'b0, steady_exp});
      else check(req, {4'b0, led == {4{red}}, grn == red}, 6'b000011);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    edges(3);
    check("R7", {led, grn, red}, 6'b0);
    @(negedge clk); rst = 1'b0;
    edges(1);
    check("R7", {led, grn, red}, 6'b0);
  endtask

  task automatic t_fault();
    int tog;
    @(negedge clk); pg = 1'b0; prog = 1'b1; ua = 1'b1; ub = 1'b0; rx = 1'b0; boot = 1'b0;
    edges(6);
    count_toggles("R1/R6 unison", 1, 5'b0, 1'b0, tog);
    check("R1 blink rate", 6'(tog), 6'd4);
    @(negedge clk); rx = 1'b1;
  endtask

  task automatic t_prog();
    int tog;
    @(negedge clk); pg = 1'b1; prog = 1'b1; ua = 1'b0; ub = 1'b0; tx = 1'b0; boot = 1'b1;
    edges(6);
    count_toggles("R2/R6 prog steady", 0, 5'b11111, 1'b1, tog);
    check("R2 red toggle rate", 6'(tog), 6'd4);
    @(negedge clk); tx = 1'b1;
  endtask

  task automatic t_latency();
    @(negedge clk); pg = 1'b1; prog = 1'b0; ua = 1'b0; ub = 1'b0; boot = 1'b1;
    edges(HOLD + 8);
    check("R5 qspi green", {led, grn, red}, 6'b000010);
    @(negedge clk); ua = 1'b1; boot = 1'b0;
    edges(2);
    check("R8 not early", {led, grn, red}, 6'b000010);
    edges(1);
    check("R8/R3/R5 arrive", {led, grn, red}, 6'b010011);
    @(negedge clk); ua = 1'b0; ub = 1'b1;
    edges(3);
    check("R3 user b", {led, grn, red}, 6'b100011);
    @(negedge clk); prog = 1'b1;
    edges(3);
    check("R8 prog arrives", {led, grn}, 6'b011111);
    @(negedge clk); prog = 1'b0; ub = 1'b0; boot = 1'b1;
    edges(3);
    check("R6 run restored", {led, grn, red}, 6'b000010);
  endtask

  task automatic t_uart(input int idx);
    logic [3:0] m;
    m = (idx == 0) ? 4'b0001 : 4'b0010;
    @(negedge clk); if (idx == 0) rx = 1'b0; else tx = 1'b0;
    edges(3);
    check("R4 dark before 4", {2'b0, led}, 6'b0);
    edges(1);
    check("R4 lit at 4", {2'b0, led}, {2'b0, m});
    edges(3);
    @(negedge clk); if (idx == 0) rx = 1'b1; else tx = 1'b1;
    edges(HOLD + 2);
    check("R4 still lit", {2'b0, led}, {2'b0, m});
    edges(1);
    check("R4 dark after hold", {2'b0, led}, 6'b0);
  endtask

  initial begin
    t_reset();
    t_fault();
    t_prog();
    t_latency();
    t_uart(0);
    t_uart(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule